// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status

This block is the maintenance section of a virtual interrupt controller interface. It holds a parameterised bank of list entries. Each entry has a 2-bit state and a flag that requests an end-of-interrupt notification. From the bank, a set of hypervisor cause enables, the two virtual group enables and a flag saying that an end-of-interrupt count is non-zero, it derives an 8-bit maintenance status word. It also builds two 32-bit end-of-interrupt status words, one bit per entry. A single maintenance interrupt output is asserted when any status cause is present and the global enable is set.

Software writes entries through a simple write strobe. It reads back the status word, both end-of-interrupt words, a fixed type word and individual entries through a registered read port. Prioritisation and the virtual acknowledge path live elsewhere.

Top module: `virq_maint`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `maint_irq` and `rd_data` are 0, and every entry reads back as state 00 with its request flag clear.
- R2: A write with `lr_we` high and `lr_idx` below `NUM_LR` stores `lr_state` and `lr_eoi_req` into that entry. A write to an index at or above `NUM_LR` changes nothing. Reading address 0x40+i returns the request flag of entry i in bit 2 and its state in bits 1:0, and returns zero for unimplemented entries.
- R3: The status word (address 0) has bit 0 EOI, bit 1 underflow, bit 2 entry-not-present, bit 3 no-pending, bit 4 group0-enabled, bit 5 group0-disabled, bit 6 group1-enabled and bit 7 group1-disabled. Bits 31:8 read as 0.
- R4: Underflow is set when `cause_en[0]` is 1 and at most one entry has a non-zero state.
- R5: No-pending is set when `cause_en[2]` is 1 and no entry has state bit 0 set. The state encoding is 00 invalid, 01 pending, 10 active and 11 pending-and-active.
- R6: Entry-not-present is set when `cause_en[1]` is 1 and `eoi_cnt_nz` is 1.
- R7: Group bits 4, 5, 6 and 7 are enabled by `cause_en[3]`, `cause_en[4]`, `cause_en[5]` and `cause_en[6]` respectively. Bit 4 needs `vm_grp0_en`=1, bit 5 needs `vm_grp0_en`=0, bit 6 needs `vm_grp1_en`=1 and bit 7 needs `vm_grp1_en`=0.
- R8: The end-of-interrupt bit of entry i is 1 when its state is 00 and its request flag is 1. Entries 0–31 appear in the word at address 2 and entries 32–63 in the word at address 3. Bits of unimplemented entries read as 0. Status bit 0 is the OR of all these bits.
- R9: The type word (address 1) is {3'b100, 3'b100, 20'b0, NUM_LR-1}.
- R10: `maint_irq` equals, one clock later, `glb_en` AND the OR of the status bits.
- R11: When `glb_en` is 0, `maint_irq` is 0 on the next cycle, whatever the status.
- R12: `rd_data` takes the value at `rd_addr` one clock after a cycle with `rd_en` high and otherwise holds. Unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global maintenance enable |
| cause_en | input | 7 | Per-cause enables for status bits 1..7 |
| vm_grp0_en | input | 1 | Virtual group 0 enable |
| vm_grp1_en | input | 1 | Virtual group 1 enable |
| eoi_cnt_nz | input | 1 | End-of-interrupt count is non-zero |
| lr_we | input | 1 | Entry write strobe |
| lr_idx | input | 6 | Entry index for a write |
| lr_state | input | 2 | Entry state to write |
| lr_eoi_req | input | 1 | Entry end-of-interrupt request flag to write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Read address |
| rd_data | output | 32 | Registered read data |
| maint_irq | output | 1 | Registered maintenance interrupt |

## Verification
A corrupted entry changes the status word, an end-of-interrupt word and `maint_irq` within one clock of the write. Those values are compared against arithmetic over a bench model across every state and request combination of four entries that straddle the 32-entry word boundary. A wrong cause gating or group polarity shows on the status read and on `maint_irq` in the next cycle, and is exposed by sweeping all cause enables, group enables and the count flag against two entry patterns. Entry read-back after an out-of-range write shows whether a stray write reached the bank.

// File: rtl/virq_maint_pkg.sv
package virq_maint_pkg;

    typedef enum logic [1:0] {
        LRS_IDLE = 2'b00,
        LRS_PEND = 2'b01,
        LRS_ACT  = 2'b10,
        LRS_BOTH = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic      eoi_req;
        lr_state_e st;
    } lr_entry_t;

    typedef struct packed {
        logic grp1_off;
        logic grp1_on;
        logic grp0_off;
        logic grp0_on;
        logic no_pend;
        logic not_present;
        logic underflow;
        logic eoi;
    } maint_stat_t;

    localparam int          MAX_LR    = 64;
    localparam int          WORD_W    = 32;
    localparam logic [2:0]  PRI_FIELD = 3'b100;
    localparam logic [2:0]  PRE_FIELD = 3'b100;

    localparam logic [6:0]  A_STAT    = 7'h00;
    localparam logic [6:0]  A_TYPE    = 7'h01;
    localparam logic [6:0]  A_EOIW0   = 7'h02;
    localparam logic [6:0]  A_EOIW1   = 7'h03;

    function automatic logic is_pending(lr_entry_t e);
        return e.st[0];
    endfunction

    function automatic logic is_valid(lr_entry_t e);
        return e.st != LRS_IDLE;
    endfunction

    function automatic logic wants_eoi(lr_entry_t e);
        return (e.st == LRS_IDLE) && e.eoi_req;
    endfunction

    function automatic logic [WORD_W-1:0] type_word(int n);
        return {PRI_FIELD, PRE_FIELD, 20'b0, 6'(n - 1)};
    endfunction

endpackage

// File: rtl/virq_maint_lrbank.sv
module virq_maint_lrbank
    import virq_maint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [5:0]        widx,
    input  lr_entry_t         wentry,
    input  logic [5:0]        ridx,
    output lr_entry_t         rentry,
    output logic [NUM_LR-1:0] valid_vec,
    output logic [NUM_LR-1:0] pend_vec,
    output logic [NUM_LR-1:0] eoi_vec
);
    localparam int EW = $bits(lr_entry_t);

    lr_entry_t            ent [NUM_LR];
    logic [NUM_LR*EW-1:0] flat;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else if (we && widx == 6'(i)) begin
                ent[i] <= wentry;
            end
        end
        assign valid_vec[i]        = is_valid(ent[i]);
        assign pend_vec[i]         = is_pending(ent[i]);
        assign eoi_vec[i]          = wants_eoi(ent[i]);
        assign flat[i*EW +: EW]    = ent[i];
    end

    always_comb begin
        rentry = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (ridx == 6'(i)) rentry = ent[i];
        end
    end

    // R2: an out-of-range write leaves every entry untouched
    p_oor_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && ({1'b0, widx} >= 7'(NUM_LR))) |=> $stable(flat));

endmodule

// File: rtl/virq_maint_eoiw.sv
module virq_maint_eoiw
    import virq_maint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic [NUM_LR-1:0] eoi_vec,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1
);
    logic [MAX_LR-1:0] padded;

    for (genvar b = 0; b < MAX_LR; b++) begin : g_pad
        if (b < NUM_LR) begin : g_impl
            assign padded[b] = eoi_vec[b];
        end else begin : g_none
            assign padded[b] = 1'b0;
        end
    end

    assign word0 = padded[WORD_W-1:0];
    assign word1 = padded[MAX_LR-1:WORD_W];

endmodule

// File: rtl/virq_maint_status.sv
module virq_maint_status
    import virq_maint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic [NUM_LR-1:0] valid_vec,
    input  logic [NUM_LR-1:0] pend_vec,
    input  logic [WORD_W-1:0] eoi_w0,
    input  logic [WORD_W-1:0] eoi_w1,
    input  logic [6:0]        cause_en,
    input  logic              vm_grp0_en,
    input  logic              vm_grp1_en,
    input  logic              eoi_cnt_nz,
    output maint_stat_t       stat
);
    logic few_valid;

    // at most one bit set: clearing the lowest set bit leaves nothing
    assign few_valid = (valid_vec & (valid_vec - 1'b1)) == '0;

    always_comb begin
        stat             = '0;
        stat.eoi         = |{eoi_w1, eoi_w0};
        stat.underflow   = cause_en[0] && few_valid;
        stat.not_present = cause_en[1] && eoi_cnt_nz;
        stat.no_pend     = cause_en[2] && (pend_vec == '0);
        stat.grp0_on     = cause_en[3] &&  vm_grp0_en;
        stat.grp0_off    = cause_en[4] && !vm_grp0_en;
        stat.grp1_on     = cause_en[5] &&  vm_grp1_en;
        stat.grp1_off    = cause_en[6] && !vm_grp1_en;
    end

endmodule

// File: rtl/virq_maint_rdport.sv
module virq_maint_rdport
    import virq_maint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [6:0]        rd_addr,
    input  maint_stat_t       stat,
    input  logic [WORD_W-1:0] eoi_w0,
    input  logic [WORD_W-1:0] eoi_w1,
    input  lr_entry_t         rentry,
    output logic [WORD_W-1:0] rd_data
);
    localparam logic [WORD_W-1:0] TYPE_W = type_word(NUM_LR);

    logic [WORD_W-1:0] sel;
    logic              stat_rd_q;

    always_comb begin
        sel = '0;
        if (rd_addr[6]) begin
            sel = WORD_W'(rentry);
        end else begin
            unique case (rd_addr)
                A_STAT:  sel = WORD_W'(stat);
                A_TYPE:  sel = TYPE_W;
                A_EOIW0: sel = eoi_w0;
                A_EOIW1: sel = eoi_w1;
                default: sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            stat_rd_q <= 1'b0;
        end else begin
            stat_rd_q <= rd_en && (rd_addr == A_STAT);
            if (rd_en) rd_data <= sel;
        end
    end

    // R3: upper bits of a status read are always zero
    p_stat_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
        stat_rd_q |-> (rd_data[WORD_W-1:8] == '0));

endmodule

// File: rtl/virq_maint.sv
module virq_maint
    import virq_maint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        glb_en,
    input  logic [6:0]  cause_en,
    input  logic        vm_grp0_en,
    input  logic        vm_grp1_en,
    input  logic        eoi_cnt_nz,
    input  logic        lr_we,
    input  logic [5:0]  lr_idx,
    input  logic [1:0]  lr_state,
    input  logic        lr_eoi_req,
    input  logic        rd_en,
    input  logic [6:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        maint_irq
);
    lr_entry_t         wentry;
    lr_entry_t         rentry;
    logic [NUM_LR-1:0] valid_vec;
    logic [NUM_LR-1:0] pend_vec;
    logic [NUM_LR-1:0] eoi_vec;
    logic [WORD_W-1:0] eoi_w0;
    logic [WORD_W-1:0] eoi_w1;
    maint_stat_t       stat;

    assign wentry = '{eoi_req: lr_eoi_req, st: lr_state_e'(lr_state)};

    virq_maint_lrbank #(.NUM_LR(NUM_LR)) u_bank (
        .clk(clk), .rst(rst), .we(lr_we), .widx(lr_idx), .wentry(wentry),
        .ridx(rd_addr[5:0]), .rentry(rentry),
        .valid_vec(valid_vec), .pend_vec(pend_vec), .eoi_vec(eoi_vec)
    );

    virq_maint_eoiw #(.NUM_LR(NUM_LR)) u_eoiw (
        .eoi_vec(eoi_vec), .word0(eoi_w0), .word1(eoi_w1)
    );

    virq_maint_status #(.NUM_LR(NUM_LR)) u_stat (
        .valid_vec(valid_vec), .pend_vec(pend_vec),
        .eoi_w0(eoi_w0), .eoi_w1(eoi_w1),
        .cause_en(cause_en), .vm_grp0_en(vm_grp0_en), .vm_grp1_en(vm_grp1_en),
        .eoi_cnt_nz(eoi_cnt_nz), .stat(stat)
    );

    virq_maint_rdport #(.NUM_LR(NUM_LR)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .stat(stat), .eoi_w0(eoi_w0), .eoi_w1(eoi_w1), .rentry(rentry),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) maint_irq <= 1'b0;
        else     maint_irq <= glb_en && (stat != '0);
    end

    // R11: interrupt never follows a cycle with the global enable low
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> !maint_irq);

    // R10: an enabled cause raises the interrupt on the next cycle
    p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
        (glb_en && stat != '0) |=> maint_irq);

    // R8: the EOI status bit agrees with the per-entry bank flags
    p_eoi_any_r8: assert property (@(posedge clk) disable iff (rst)
        stat.eoi == (eoi_vec != '0));

    // R5: with no pending entry in the bank and the cause enabled, no-pending is reported
    p_nopend_r5: assert property (@(posedge clk) disable iff (rst)
        (cause_en[2] && pend_vec == '0) |-> stat.no_pend);

endmodule

// File: tb/virq_maint_test.sv
module virq_maint_test;
    localparam int CLK_P  = 10;
    localparam int NUM_LR = 34;

    logic        clk = 1'b0;
    logic        rst;
    logic        glb_en;
    logic [6:0]  cause_en;
    logic        vm_grp0_en, vm_grp1_en, eoi_cnt_nz;
    logic        lr_we;
    logic [5:0]  lr_idx;
    logic [1:0]  lr_state;
    logic        lr_eoi_req;
    logic        rd_en;
    logic [6:0]  rd_addr;
    logic [31:0] rd_data;
    logic        maint_irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [1:0] m_st [64];
    logic       m_rq [64];

    virq_maint #(.NUM_LR(NUM_LR)) uut (
        .clk(clk), .rst(rst), .glb_en(glb_en), .cause_en(cause_en),
        .vm_grp0_en(vm_grp0_en), .vm_grp1_en(vm_grp1_en), .eoi_cnt_nz(eoi_cnt_nz),
        .lr_we(lr_we), .lr_idx(lr_idx), .lr_state(lr_state), .lr_eoi_req(lr_eoi_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .maint_irq(maint_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [1:0] st, input logic rq);
        lr_we = 1'b1; lr_idx = 6'(idx); lr_state = st; lr_eoi_req = rq;
        @(negedge clk);
        lr_we = 1'b0;
        if (idx < NUM_LR) begin m_st[idx] = st; m_rq[idx] = rq; end
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [63:0] exp_eoi();
        logic [63:0] v = '0;
        for (int i = 0; i < NUM_LR; i++) v[i] = (m_st[i] == 2'b00) && m_rq[i];
        return v;
    endfunction

    function automatic logic [31:0] exp_stat();
        int nval = 0;
        logic anyp = 1'b0;
        logic [7:0] s;
        for (int i = 0; i < NUM_LR; i++) begin
            if (m_st[i] != 2'b00) nval++;
            if (m_st[i][0]) anyp = 1'b1;
        end
        s[0] = exp_eoi() != '0;
        s[1] = cause_en[0] && (nval <= 1);
        s[2] = cause_en[1] && eoi_cnt_nz;
        s[3] = cause_en[2] && !anyp;
        s[4] = cause_en[3] && vm_grp0_en;
        s[5] = cause_en[4] && !vm_grp0_en;
        s[6] = cause_en[5] && vm_grp1_en;
        s[7] = cause_en[6] && !vm_grp1_en;
        return {24'b0, s};
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] e;
        int sel [4] = '{0, 1, 32, 33};

        for (int i = 0; i < 64; i++) begin m_st[i] = 2'b00; m_rq[i] = 1'b0; end
        rst = 1'b1; glb_en = 1'b0; cause_en = '0; vm_grp0_en = 1'b0; vm_grp1_en = 1'b0;
        eoi_cnt_nz = 1'b0; lr_we = 1'b0; lr_idx = '0; lr_state = '0; lr_eoi_req = 1'b0;
        rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(maint_irq), 0);
        check("R1 rd_data in reset", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", 32'(maint_irq), 0);
        rd(7'h40 + 7'd33, d); check("R1 entry 33 after reset", d, 0);
        rd(7'h00, d);         check("R1 status after reset", d, 0);

        rd(7'h01, d); check("R9 type word", d, {3'b100, 3'b100, 20'b0, 6'(NUM_LR - 1)});
        rd(7'h05, d); check("R12 unmapped address", d, 0);
        rd(7'h01, d);
        @(negedge clk);
        check("R12 rd_data holds without rd_en", rd_data, {3'b100, 3'b100, 20'b0, 6'(NUM_LR - 1)});

        wr(33, 2'b11, 1'b1);
        rd(7'h40 + 7'd33, d); check("R2 entry 33 readback", d, 32'h7);
        wr(40, 2'b01, 1'b1);
        rd(7'h40 + 7'd40, d); check("R2 unimplemented entry reads zero", d, 0);
        for (int i = 0; i < NUM_LR; i++) begin
            rd(7'h40 + 7'(i), d);
            check("R2 out-of-range write ignored", d, {29'b0, m_rq[i], m_st[i]});
        end
        wr(33, 2'b00, 1'b0);

        // exhaustive sweep of four entries straddling the word boundary
        glb_en = 1'b1; cause_en = 7'h7F; vm_grp0_en = 1'b1; vm_grp1_en = 1'b0; eoi_cnt_nz = 1'b0;
        for (int c = 0; c < 4096; c++) begin
            for (int j = 0; j < 4; j++) wr(sel[j], 2'((c >> (2*j)) & 3), 1'((c >> (8+j)) & 1));
            e = exp_eoi();
            rd(7'h00, d); check("R3 R4 R5 R7 status sweep", d, exp_stat());
            check("R10 irq sweep", 32'(maint_irq), 32'(exp_stat() != 0));
            rd(7'h02, d); check("R8 eoi word 0", d, e[31:0]);
            rd(7'h03, d); check("R8 eoi word 1", d, e[63:32]);
        end

        // control sweep over two entry patterns
        for (int p = 0; p < 2; p++) begin
            for (int j = 0; j < 4; j++) wr(sel[j], 2'b00, 1'b0);
            if (p == 1) begin wr(0, 2'b01, 1'b0); wr(33, 2'b10, 1'b0); end
            for (int k = 0; k < 2048; k++) begin
                cause_en = 7'(k); glb_en = k[7]; vm_grp0_en = k[8];
                vm_grp1_en = k[9]; eoi_cnt_nz = k[10];
                @(negedge clk);
                check(glb_en ? "R10 irq control sweep" : "R11 irq gated off",
                      32'(maint_irq), 32'(glb_en && exp_stat() != 0));
                rd(7'h00, d); check("R6 R7 R4 R5 status control sweep", d, exp_stat());
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule